// File: doc/BRIEF.md
# Bidirectional Cascadable Column Data Capture

This block is the digital front end of one column-driver slice. Each clock a 36-bit bus brings six 6-bit gray codes, which is two RGB pixels. A start pulse arms a one-hot slot pointer. The pointer then steps through 64 slots and stores each six-code group in a 64-group line register. A direction input sets two things: which start pin is the input, and whether the groups fill from output 0 upward or from output 383 downward.

A single-cycle hand-off pulse on the opposite start pin starts the next slice in a chain, so a wide panel line streams through several slices one after another. A per-clock inversion input stores codes complemented. A rising edge on the load input copies the whole line register into a line latch and ends the current capture. The latch is presented as one flat vector for the conversion stage that follows this block.

Top module: `disp_capture`

## Requirements
- R1: After a synchronous active-high reset, `line_q` is all zeros and both `st_right_out` and `st_left_out` are low.
- R2: With `fill_right` high, a high `st_right_in` at a rising clock edge accepts a start. The bus word at that edge goes to group 0, and the word at the k-th edge after it goes to group k. Lane l of group g (bits `6l+5:6l` of `pix_bus`) appears on output `6g+l`, which is bits `(6g+l)*6+5 : (6g+l)*6` of `line_q`. Bit 0 of each code is its LSB.
- R3: With `fill_right` low, the start is taken from `st_left_in` and the k-th captured word goes to group 63-k. The lane order inside a group stays the same as in R2.
- R4: While `fill_right` is high, `st_left_in` is ignored. While it is low, `st_right_in` is ignored. A pulse on the ignored pin stores nothing.
- R5: The hand-off pulse is high for exactly one cycle, right after the edge that captures the last slot (the 64th edge, counting the start edge). It appears on `st_left_out` when `fill_right` is high and on `st_right_out` when it is low. The other output pin stays low.
- R6: Once 66 clocks have passed since the start, no bus value is stored until the next accepted start.
- R7: When `invert` is high at a capturing edge, the stored word is the bitwise complement of the bus. When it is low, the word is stored as it is.
- R8: A rising edge of `load`, sampled on the clock, copies the line register into `line_q` as it stood before that edge. `line_q` changes at no other time except reset.
- R9: A start accepted while a line is still being captured restarts the pointer at slot 0. The hand-off pulse then follows the restart, not the earlier start.
- R10: The clock edge that sees a `load` rise stores nothing, clears the pointer and ignores any start. Later edges store nothing until a new start arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fill_right | input | 1 | Direction: 1 fills from output 0 upward, 0 from output 383 downward |
| st_right_in | input | 1 | Start input used when `fill_right` is high |
| st_left_in | input | 1 | Start input used when `fill_right` is low |
| st_right_out | output | 1 | Hand-off pulse when `fill_right` is low |
| st_left_out | output | 1 | Hand-off pulse when `fill_right` is high |
| pix_bus | input | 36 | Six 6-bit gray codes, lane l at bits 6l+5:6l |
| invert | input | 1 | Store codes complemented at this edge |
| load | input | 1 | Rising edge transfers the line register to the latch |
| line_q | output | 2304 | Latched line, output j at bits 6j+5:6j |

## Verification
The risky overlap is a `load` rise that falls on an edge where the pointer would otherwise store a slot. In that case the latch must take the older register contents, that slot must not be written, and every later word must be dropped. The bench provokes this by raising `load` partway through a new line, together with a stray start pulse on the same edge. It then predicts the latch as a mix: new groups below the collision slot and the previous line's groups from that slot on. A second load after more bus traffic must then reproduce exactly the same mixed image.

// File: rtl/disp_cap_pkg.sv
package disp_cap_pkg;

  localparam int unsigned DEF_CODE_W = 6;
  localparam int unsigned DEF_LANES  = 6;
  localparam int unsigned DEF_SLOTS  = 64;
  localparam int unsigned DEF_SPAN   = 66;

  // Map a pointer slot onto a storage group for the chosen fill order.
  function automatic int unsigned grp_of(int unsigned slot, logic right,
                                         int unsigned slots);
    return right ? slot : (slots - 1 - slot);
  endfunction

endpackage

// File: rtl/disp_slot_ptr.sv
module disp_slot_ptr #(
  parameter int unsigned SLOTS = 64,
  parameter int unsigned SPAN  = 66
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             clear,
  output logic [SLOTS-1:0] slot_hot,
  output logic             last_hit
);

  // Positions SLOTS..SPAN-1 are idle tail clocks after the last slot.
  logic [SPAN-1:0] hot_q;
  logic [SPAN-1:0] sel;

  always_comb begin
    if (clear)      sel = '0;
    else if (start) sel = SPAN'(1);
    else            sel = hot_q;
    slot_hot = sel[SLOTS-1:0];
    last_hit = sel[SLOTS-1];
  end

  always_ff @(posedge clk) begin
    if (rst) hot_q <= '0;
    else     hot_q <= sel << 1;
  end

endmodule

// File: rtl/disp_line_store.sv
module disp_line_store #(
  parameter int unsigned GROUPS = 64,
  parameter int unsigned BUS_W  = 36,
  localparam int unsigned IDX_W  = $clog2(GROUPS),
  localparam int unsigned LINE_W = GROUPS * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_grp,
  input  logic [BUS_W-1:0]  wr_word,
  input  logic              copy,
  output logic [LINE_W-1:0] line_q
);

  logic [BUS_W-1:0] mem [GROUPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int g = 0; g < GROUPS; g++) mem[g] <= '0;
    end else if (wr_en) begin
      mem[wr_grp] <= wr_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
    end else if (copy) begin
      for (int g = 0; g < GROUPS; g++) line_q[g*BUS_W +: BUS_W] <= mem[g];
    end
  end

endmodule

// File: rtl/disp_capture.sv
module disp_capture
  import disp_cap_pkg::*;
#(
  parameter int unsigned CODE_W = DEF_CODE_W,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned SLOTS  = DEF_SLOTS,
  parameter int unsigned SPAN   = DEF_SPAN,
  localparam int unsigned BUS_W  = LANES * CODE_W,
  localparam int unsigned LINE_W = SLOTS * BUS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fill_right,
  input  logic              st_right_in,
  input  logic              st_left_in,
  output logic              st_right_out,
  output logic              st_left_out,
  input  logic [BUS_W-1:0]  pix_bus,
  input  logic              invert,
  input  logic              load,
  output logic [LINE_W-1:0] line_q
);

  localparam int unsigned IDX_W = $clog2(SLOTS);

  logic             start_sel;
  logic             load_q;
  logic             load_rise;
  logic [SLOTS-1:0] slot_hot;
  logic             last_hit;
  logic [IDX_W-1:0] slot_idx;
  logic             slot_any;
  logic [IDX_W-1:0] wr_grp;
  logic [BUS_W-1:0] wr_word;

  assign start_sel = fill_right ? st_right_in : st_left_in;

  always_ff @(posedge clk) load_q <= load;
  assign load_rise = load & ~load_q;

  disp_slot_ptr #(.SLOTS(SLOTS), .SPAN(SPAN)) u_ptr (
    .clk      (clk),
    .rst      (rst),
    .start    (start_sel),
    .clear    (load_rise),
    .slot_hot (slot_hot),
    .last_hit (last_hit)
  );

  always_comb begin
    slot_idx = '0;
    slot_any = 1'b0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot_hot[s]) begin
        slot_idx = IDX_W'(s);
        slot_any = 1'b1;
      end
    end
    wr_grp = IDX_W'(grp_of(int'(slot_idx), fill_right, SLOTS));
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign wr_word[l*CODE_W +: CODE_W] =
      invert ? ~pix_bus[l*CODE_W +: CODE_W] : pix_bus[l*CODE_W +: CODE_W];
  end

  disp_line_store #(.GROUPS(SLOTS), .BUS_W(BUS_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (slot_any),
    .wr_grp  (wr_grp),
    .wr_word (wr_word),
    .copy    (load_rise),
    .line_q  (line_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_right_out <= 1'b0;
      st_left_out  <= 1'b0;
    end else begin
      st_right_out <= last_hit & ~fill_right;
      st_left_out  <= last_hit & fill_right;
    end
  end

endmodule

// File: rtl/disp_capture_chk.sv
module disp_capture_chk #(
  parameter int unsigned LINE_W = 2304
) (
  input logic              clk,
  input logic              rst,
  input logic              fill_right,
  input logic              load,
  input logic              st_right_out,
  input logic              st_left_out,
  input logic [LINE_W-1:0] line_q
);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (line_q == '0) && !st_right_out && !st_left_out);

  // R5
  handoff_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(st_right_out && st_left_out));

  // R5
  handoff_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (st_right_out || st_left_out) |=> !(st_right_out || st_left_out));

  // R5
  handoff_left_chk: assert property (@(posedge clk) disable iff (rst)
    st_left_out |-> $past(fill_right));

  // R5
  handoff_right_chk: assert property (@(posedge clk) disable iff (rst)
    st_right_out |-> !$past(fill_right));

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(load && !$past(load)) |=> $stable(line_q));

  // R10
  load_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !$past(load)) |=> !(st_right_out || st_left_out));

endmodule

bind disp_capture disp_capture_chk #(.LINE_W(LINE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .fill_right   (fill_right),
  .load         (load),
  .st_right_out (st_right_out),
  .st_left_out  (st_left_out),
  .line_q       (line_q)
);

// File: tb/test_disp_capture.sv
module test_disp_capture;

  localparam int SLOTS  = 64;
  localparam int BUS_W  = 36;
  localparam int LINE_W = SLOTS * BUS_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              fill_right = 1'b1;
  logic              st_right_in = 1'b0;
  logic              st_left_in = 1'b0;
  logic              st_right_out;
  logic              st_left_out;
  logic [BUS_W-1:0]  pix_bus = '0;
  logic              invert = 1'b0;
  logic              load = 1'b0;
  logic [LINE_W-1:0] line_q;

  int n_chk  = 0;
  int n_fail = 0;

  logic [BUS_W-1:0] exp_reg [SLOTS];
  logic [BUS_W-1:0] exp_lat [SLOTS];

  always #10 clk = ~clk;

  disp_capture i_disp_capture (
    .clk          (clk),
    .rst          (rst),
    .fill_right   (fill_right),
    .st_right_in  (st_right_in),
    .st_left_in   (st_left_in),
    .st_right_out (st_right_out),
    .st_left_out  (st_left_out),
    .pix_bus      (pix_bus),
    .invert       (invert),
    .load         (load),
    .line_q       (line_q)
  );

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [BUS_W-1:0] pat(int k, int seed);
    logic [5:0] a = 6'(k);
    logic [5:0] b = 6'(seed);
    return {a ^ b, a + b, ~a, b, a, 6'(k * 5 + seed)};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmp_line(string req);
    bit ok = 1'b1;
    int bad = 0;
    for (int g = 0; g < SLOTS; g++) begin
      if (ok && line_q[g*BUS_W +: BUS_W] !== exp_lat[g]) begin
        ok = 1'b0;
        bad = g;
      end
    end
    chk(ok, req, 64'(line_q[bad*BUS_W +: BUS_W]), 64'(exp_lat[bad]));
  endtask

  task automatic do_load();
    load = 1'b1;
    for (int g = 0; g < SLOTS; g++) exp_lat[g] = exp_reg[g];
    tick();
    load = 1'b0;
    tick();
  endtask

  // Drive n clocks of one line; start at the first clock; track hand-off.
  task automatic run_line(bit dir, int seed, bit inv_odd, int n, string req);
    bit ok = 1'b1;
    fill_right = dir;
    for (int k = 0; k < n; k++) begin
      if (dir) st_right_in = (k == 0);
      else     st_left_in  = (k == 0);
      pix_bus = pat(k, seed);
      invert  = inv_odd && k[0];
      tick();
      exp_reg[dir ? k : SLOTS - 1 - k] = invert ? ~pat(k, seed) : pat(k, seed);
      if (dir  && (st_left_out  !== (k == SLOTS - 1) || st_right_out !== 1'b0)) ok = 1'b0;
      if (!dir && (st_right_out !== (k == SLOTS - 1) || st_left_out  !== 1'b0)) ok = 1'b0;
    end
    st_right_in = 1'b0;
    st_left_in  = 1'b0;
    invert      = 1'b0;
    chk(ok, req, {62'd0, st_right_out, st_left_out}, 64'd0);
  endtask

  task automatic t_reset();
    cmp_line("R1 line_q after reset");
    chk(!st_right_out && !st_left_out, "R1 hand-off pins after reset",
        {62'd0, st_right_out, st_left_out}, 64'd0);
  endtask

  task automatic t_right_fill();
    run_line(1'b1, 5, 1'b0, SLOTS, "R5 hand-off on left pin, fill right");
    tick();
    chk(!st_left_out && !st_right_out, "R5 pulse lasts one cycle",
        {62'd0, st_right_out, st_left_out}, 64'd0);
    cmp_line("R8 latch holds while filling");
    do_load();
    cmp_line("R2 right fill image");
    chk(line_q[5:0] === pat(0, 5)[5:0], "R2 output 0 gets lane 0 of first word",
        64'(line_q[5:0]), 64'(pat(0, 5)[5:0]));
  endtask

  task automatic t_left_fill();
    run_line(1'b0, 17, 1'b0, SLOTS, "R5 hand-off on right pin, fill left");
    do_load();
    cmp_line("R3 left fill image");
    chk(line_q[LINE_W-BUS_W +: 6] === pat(0, 17)[5:0],
        "R3 first word lane 0 lands on output 378",
        64'(line_q[LINE_W-BUS_W +: 6]), 64'(pat(0, 17)[5:0]));
  endtask

  task automatic t_invert();
    run_line(1'b1, 29, 1'b1, SLOTS, "R7 hand-off during inverted line");
    do_load();
    cmp_line("R7 odd slots stored complemented");
  endtask

  task automatic t_stop();
    run_line(1'b1, 41, 1'b0, SLOTS, "R6 hand-off before overrun");
    for (int k = 0; k < 12; k++) begin
      pix_bus = pat(k, 50);
      tick();
    end
    do_load();
    cmp_line("R6 no capture after 66 clocks");
  endtask

  task automatic t_wrong_pin();
    fill_right = 1'b1;
    st_left_in = 1'b1;
    pix_bus = pat(0, 60);
    tick();
    st_left_in = 1'b0;
    for (int k = 1; k < 70; k++) begin
      pix_bus = pat(k, 60);
      tick();
      if (st_left_out || st_right_out)
        chk(1'b0, "R4 ignored start produced hand-off", 64'd1, 64'd0);
    end
    do_load();
    cmp_line("R4 start on unselected pin ignored");
  endtask

  task automatic t_restart();
    run_line(1'b1, 3, 1'b0, 20, "R9 no hand-off in aborted part");
    run_line(1'b1, 9, 1'b0, SLOTS, "R9 hand-off follows restart");
    do_load();
    cmp_line("R9 restarted line image");
  endtask

  task automatic t_collide();
    run_line(1'b1, 22, 1'b0, 20, "R10 partial line before load");
    pix_bus = pat(20, 22);
    st_right_in = 1'b1;
    load = 1'b1;
    for (int g = 0; g < SLOTS; g++) exp_lat[g] = exp_reg[g];
    tick();
    st_right_in = 1'b0;
    load = 1'b0;
    cmp_line("R8 latch takes register before collision edge");
    for (int k = 21; k < 70; k++) begin
      pix_bus = pat(k, 33);
      tick();
      if (st_left_out || st_right_out)
        chk(1'b0, "R10 hand-off after load cleared pointer", 64'd1, 64'd0);
    end
    do_load();
    cmp_line("R10 nothing stored after load rise");
  endtask

  initial begin
    for (int g = 0; g < SLOTS; g++) begin
      exp_reg[g] = '0;
      exp_lat[g] = '0;
    end
    repeat (3) tick();
    rst = 1'b0;
    tick();
    t_reset();
    t_right_fill();
    t_left_fill();
    t_invert();
    t_stop();
    t_wrong_pin();
    t_restart();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule